// File: doc/BRIEF.md
# Unaligned Flash Write Merger

The merger turns a byte stream that starts at any byte address into a series of port-width words, each aligned to the port width, ready for a flash programming engine. When the first or last word is only partly covered by the stream, the byte positions the stream does not reach are filled with the bytes already stored in the flash. The merger fetches them with a read-back request for that word. Words that the stream covers completely never cause a read. This keeps erased or previously written bytes next to the new data unchanged.

A request is a one-cycle start pulse with a byte address and a length. Bytes then arrive on a valid/ready stream. Finished words leave on a valid/ready write port together with a burst-end flag. The flag cuts the fully covered middle of the transfer into chunks that fit the parallel chips' write buffers. Bytes are packed into a word by shifting: in big-endian mode the word shifts left and the new byte enters the low lane, and in little-endian mode the word shifts right and the byte enters the top lane. A separate combinational path builds a command word. It repeats a command byte once per chip and places it in the last byte lane of each chip.

Top module: `flash_write_merger`

## Requirements
- R1: Every write word address is the request address with its low log2(PORT_BYTES) bits cleared, followed by successive addresses PORT_BYTES apart.
- R2: In the first word, byte positions below the start offset hold the flash bytes read back for that word, and the stream bytes follow them.
- R3: If the stream ends inside the first word, every position after the last stream byte holds the read-back flash byte.
- R4: A partial last word holds the remaining stream bytes at its lowest positions and read-back flash bytes in all higher positions.
- R5: With BIG_ENDIAN=1, the byte at position k of a word (position 0 = lowest byte address) sits in bits [(PORT_BYTES-1-k)*8 +: 8] of the word, and read-back data uses the same layout.
- R6: With BIG_ENDIAN=0, the byte at position k sits in bits [k*8 +: 8] of the word, and read-back data uses the same layout.
- R7: A read-back request (o_rd_req with o_rd_addr = word address) is raised for a word only when that word has at least one position the stream does not cover. The request is held until i_rd_valid.
- R8: A start with zero length pulses o_done in the next cycle and produces no word and no read-back request.
- R9: o_cmd_word carries the command byte in byte position i when (i+1) mod CHIP_BYTES = 0 and zero in every other position, where position i occupies bits [(PORT_BYTES-1-i)*8 +: 8] in both endian modes (little-endian lanes are byte-swapped after placement).
- R10: o_wr_burst_end is 1 on every partial word. Over a run of fully covered words it is 1 on every CHUNK_WORDS-th word of the run and on the run's last word, where CHUNK_WORDS = (PORT_BYTES/CHIP_BYTES)*BUF_SIZE/PORT_BYTES.
- R11: After reset, o_wr_valid, o_rd_req, o_byte_ready, o_busy and o_done are all 0.
- R12: While o_wr_valid is 1 and i_wr_ready is 0, the write address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_start | input | 1 | Request pulse, taken only when idle |
| i_addr | input | ADDR_W | Byte address of the first stream byte |
| i_len | input | LEN_W | Number of stream bytes |
| i_byte_valid | input | 1 | Stream byte present |
| i_byte | input | 8 | Stream byte |
| o_byte_ready | output | 1 | Stream byte taken this cycle |
| o_rd_req | output | 1 | Read-back request for the word being built |
| o_rd_addr | output | ADDR_W | Word address to read back |
| i_rd_valid | input | 1 | Read-back data present |
| i_rd_data | input | PORT_BYTES*8 | Read-back flash word |
| o_wr_valid | output | 1 | Aligned write word present |
| o_wr_addr | output | ADDR_W | Aligned write address |
| o_wr_data | output | PORT_BYTES*8 | Merged write word |
| o_wr_burst_end | output | 1 | Last word of a write burst |
| i_wr_ready | input | 1 | Write word accepted |
| o_busy | output | 1 | Request in progress |
| o_done | output | 1 | One-cycle pulse when a request finishes |
| i_cmd_byte | input | 8 | Command byte to replicate |
| o_cmd_word | output | PORT_BYTES*8 | Command word laid out per chip lane |

## Verification
The bench builds two copies of the top with PORT_BYTES=4, CHIP_BYTES=2 and BUF_SIZE=4, one big-endian and one little-endian, and drives both in lockstep. This gives chunks of two words, so a 20-byte aligned transfer shows several burst cuts, and head offsets 1 and 3 reach both ends of the head merge. Two extra command builders with CHIP_BYTES of 1 and 4 show full replication and a single lane. A write port that stalls every third cycle exercises the hold rule on the output word.

// File: rtl/flash_merge_pkg.sv
// Shared types for the unaligned flash write merger.
package flash_merge_pkg;

    // Controller phases: idle, plan next word, wait read-back, fill lanes, offer word.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_READ,
        ST_FILL,
        ST_SEND
    } merge_state_e;

endpackage

// File: rtl/fwm_cmd_lanes.sv
// Command word builder.
// Places the command byte in the last byte position of each chip on the port
// and zero elsewhere, then swaps byte lanes when the port is little-endian.
// Assumes PORT_BYTES is a multiple of CHIP_BYTES.
module fwm_cmd_lanes #(
    parameter int PORT_BYTES = 4,
    parameter int CHIP_BYTES = 2,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [7:0]              i_cmd,
    output logic [PORT_BYTES*8-1:0] o_word
);
    localparam int W = PORT_BYTES * 8;

    logic [PORT_BYTES-1:0][7:0] lane_b;
    logic [W-1:0]               native_w;

    for (genvar i = 0; i < PORT_BYTES; i++) begin : g_lane
        localparam bit HIT = ((i + 1) % CHIP_BYTES) == 0;
        // Byte in memory order: command at the top lane of each chip.
        assign lane_b[i] = HIT ? i_cmd : 8'h00;
        if (BIG_ENDIAN) begin : g_be
            // Memory order seen as a big-endian word.
            assign native_w[(PORT_BYTES-1-i)*8 +: 8] = lane_b[i];
        end else begin : g_le
            // Memory order seen as a little-endian word.
            assign native_w[i*8 +: 8] = lane_b[i];
        end
    end

    for (genvar j = 0; j < PORT_BYTES; j++) begin : g_out
        if (BIG_ENDIAN) begin : g_keep
            // Big-endian word goes out unchanged.
            assign o_word[j*8 +: 8] = native_w[j*8 +: 8];
        end else begin : g_swap
            // Little-endian word is byte-swapped.
            assign o_word[j*8 +: 8] = native_w[(PORT_BYTES-1-j)*8 +: 8];
        end
    end

endmodule

// File: rtl/fwm_packer.sv
// Byte-serial word packer.
// Accumulates PORT_BYTES bytes into one word by shifting. Big-endian shifts
// left with the byte entering the low lane; little-endian shifts right with
// the byte entering the top lane. Assumes PORT_BYTES >= 2.
module fwm_packer #(
    parameter int PORT_BYTES = 4,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_clear,
    input  logic                    i_push,
    input  logic [7:0]              i_byte,
    output logic [PORT_BYTES*8-1:0] o_word
);
    localparam int W = PORT_BYTES * 8;

    logic [W-1:0] acc_q;

    if (BIG_ENDIAN) begin : g_be
        // Shift left, new byte into the low lane.
        always_ff @(posedge clk) begin
            if (!rst_n)       acc_q <= '0;
            else if (i_clear) acc_q <= '0;
            else if (i_push)  acc_q <= {acc_q[W-9:0], i_byte};
        end
    end else begin : g_le
        // Shift right, new byte into the top lane.
        always_ff @(posedge clk) begin
            if (!rst_n)       acc_q <= '0;
            else if (i_clear) acc_q <= '0;
            else if (i_push)  acc_q <= {i_byte, acc_q[W-1:8]};
        end
    end

    assign o_word = acc_q;

endmodule

// File: rtl/fwm_ctrl.sv
// Merge controller.
// Walks the aligned words covering a request. For each word it decides
// whether a flash read-back is needed, then feeds one byte per cycle to the
// packer, taking either a stream byte or the read-back byte for that
// position, and finally offers the word with a burst-end flag.
// Assumes PORT_BYTES is a power of two, at least 2, and CHUNK_WORDS >= 1.
module fwm_ctrl
    import flash_merge_pkg::*;
#(
    parameter int PORT_BYTES  = 4,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int CHUNK_WORDS = 16,
    parameter bit BIG_ENDIAN  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_start,
    input  logic [ADDR_W-1:0]       i_addr,
    input  logic [LEN_W-1:0]        i_len,
    input  logic                    i_byte_valid,
    input  logic [7:0]              i_byte,
    output logic                    o_byte_ready,
    output logic                    o_rd_req,
    output logic [ADDR_W-1:0]       o_rd_addr,
    input  logic                    i_rd_valid,
    input  logic [PORT_BYTES*8-1:0] i_rd_data,
    output logic                    o_push,
    output logic [7:0]              o_push_byte,
    output logic                    o_clear,
    output logic                    o_wr_valid,
    output logic [ADDR_W-1:0]       o_wr_addr,
    output logic                    o_wr_burst_end,
    input  logic                    i_wr_ready,
    output logic                    o_busy,
    output logic                    o_done
);
    localparam int W  = PORT_BYTES * 8;
    localparam int LB = $clog2(PORT_BYTES);
    localparam int CW = $clog2(CHUNK_WORDS) + 1;
    localparam logic [LEN_W-1:0]  PB_LEN     = LEN_W'(PORT_BYTES);
    localparam logic [ADDR_W-1:0] PB_ADDR    = ADDR_W'(PORT_BYTES);
    localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'(PORT_BYTES - 1);
    localparam logic [CW-1:0]     CHUNK_LAST = CW'(CHUNK_WORDS - 1);
    localparam logic [LB-1:0]     POS_LAST   = LB'(PORT_BYTES - 1);

    merge_state_e      state_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [LB-1:0]     off_q;
    logic [LB-1:0]     pos_q;
    logic [LEN_W-1:0]  remain_q;
    logic [W-1:0]      rd_word_q;
    logic              partial_q;
    logic [CW-1:0]     cnt_q;
    logic              done_q;

    logic              flash_pos;
    logic              push;
    logic              burst_end;
    logic              need_rb;
    logic [7:0]        flash_byte;

    // Position is taken from flash when below the head offset or past the stream.
    assign flash_pos = (pos_q < off_q) || (remain_q == '0);

    // Word needs read-back when it starts mid-word or the stream ends inside it.
    assign need_rb = (off_q != '0) || (remain_q < PB_LEN);

    // Pick the read-back byte for the current position in the port's byte order.
    always_comb begin
        flash_byte = 8'h00;
        for (int k = 0; k < PORT_BYTES; k++) begin
            if (LB'(k) == pos_q) begin
                flash_byte = BIG_ENDIAN ? rd_word_q[(PORT_BYTES-1-k)*8 +: 8]
                                        : rd_word_q[k*8 +: 8];
            end
        end
    end

    assign push           = (state_q == ST_FILL) && (flash_pos || i_byte_valid);
    assign o_push         = push;
    assign o_push_byte    = flash_pos ? flash_byte : i_byte;
    assign o_clear        = (state_q == ST_PLAN);
    assign o_byte_ready   = (state_q == ST_FILL) && !flash_pos;
    assign o_rd_req       = (state_q == ST_READ);
    assign o_rd_addr      = waddr_q;
    assign o_wr_valid     = (state_q == ST_SEND);
    assign o_wr_addr      = waddr_q;
    assign burst_end      = partial_q || (cnt_q == CHUNK_LAST) || (remain_q < PB_LEN);
    assign o_wr_burst_end = burst_end;
    assign o_busy         = (state_q != ST_IDLE);
    assign o_done         = done_q;

    // Request sequencing, per-word bookkeeping and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            waddr_q   <= '0;
            off_q     <= '0;
            pos_q     <= '0;
            remain_q  <= '0;
            rd_word_q <= '0;
            partial_q <= 1'b0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (i_start) begin
                        if (i_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            waddr_q  <= i_addr & ~LOW_MASK;
                            off_q    <= i_addr[LB-1:0];
                            remain_q <= i_len;
                            cnt_q    <= '0;
                            state_q  <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    partial_q <= need_rb;
                    pos_q     <= '0;
                    state_q   <= need_rb ? ST_READ : ST_FILL;
                end
                ST_READ: begin
                    if (i_rd_valid) begin
                        rd_word_q <= i_rd_data;
                        state_q   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (push) begin
                        if (!flash_pos) remain_q <= remain_q - 1'b1;
                        if (pos_q == POS_LAST) state_q <= ST_SEND;
                        else                   pos_q   <= pos_q + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (i_wr_ready) begin
                        waddr_q <= waddr_q + PB_ADDR;
                        off_q   <= '0;
                        cnt_q   <= (partial_q || burst_end) ? '0 : cnt_q + 1'b1;
                        if (remain_q == '0) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_PLAN;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_write_merger.sv
// Unaligned flash write merger, top level.
// Combines the merge controller, the shift packer and the command lane
// builder. Burst chunk length in words is derived from the port-to-chip
// ratio and the per-chip buffer size. Assumes PORT_BYTES is a power of two,
// at least 2, and a multiple of CHIP_BYTES.
module flash_write_merger #(
    parameter int PORT_BYTES = 4,
    parameter int CHIP_BYTES = 2,
    parameter int BUF_SIZE   = 32,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_start,
    input  logic [ADDR_W-1:0]       i_addr,
    input  logic [LEN_W-1:0]        i_len,
    input  logic                    i_byte_valid,
    input  logic [7:0]              i_byte,
    output logic                    o_byte_ready,
    output logic                    o_rd_req,
    output logic [ADDR_W-1:0]       o_rd_addr,
    input  logic                    i_rd_valid,
    input  logic [PORT_BYTES*8-1:0] i_rd_data,
    output logic                    o_wr_valid,
    output logic [ADDR_W-1:0]       o_wr_addr,
    output logic [PORT_BYTES*8-1:0] o_wr_data,
    output logic                    o_wr_burst_end,
    input  logic                    i_wr_ready,
    output logic                    o_busy,
    output logic                    o_done,
    input  logic [7:0]              i_cmd_byte,
    output logic [PORT_BYTES*8-1:0] o_cmd_word
);
    localparam int CHUNK_BYTES = (PORT_BYTES / CHIP_BYTES) * BUF_SIZE;
    localparam int CHUNK_RAW   = CHUNK_BYTES / PORT_BYTES;
    localparam int CHUNK_WORDS = (CHUNK_RAW < 1) ? 1 : CHUNK_RAW;

    logic       push;
    logic       clear;
    logic [7:0] push_byte;

    fwm_ctrl #(
        .PORT_BYTES (PORT_BYTES),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .CHUNK_WORDS(CHUNK_WORDS),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .i_start       (i_start),
        .i_addr        (i_addr),
        .i_len         (i_len),
        .i_byte_valid  (i_byte_valid),
        .i_byte        (i_byte),
        .o_byte_ready  (o_byte_ready),
        .o_rd_req      (o_rd_req),
        .o_rd_addr     (o_rd_addr),
        .i_rd_valid    (i_rd_valid),
        .i_rd_data     (i_rd_data),
        .o_push        (push),
        .o_push_byte   (push_byte),
        .o_clear       (clear),
        .o_wr_valid    (o_wr_valid),
        .o_wr_addr     (o_wr_addr),
        .o_wr_burst_end(o_wr_burst_end),
        .i_wr_ready    (i_wr_ready),
        .o_busy        (o_busy),
        .o_done        (o_done)
    );

    fwm_packer #(
        .PORT_BYTES(PORT_BYTES),
        .BIG_ENDIAN(BIG_ENDIAN)
    ) u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_clear(clear),
        .i_push (push),
        .i_byte (push_byte),
        .o_word (o_wr_data)
    );

    fwm_cmd_lanes #(
        .PORT_BYTES(PORT_BYTES),
        .CHIP_BYTES(CHIP_BYTES),
        .BIG_ENDIAN(BIG_ENDIAN)
    ) u_cmd (
        .i_cmd (i_cmd_byte),
        .o_word(o_cmd_word)
    );

endmodule

// File: rtl/fwm_checker.sv
// Protocol checker for the write merger, bound to every instance of the top.
module fwm_checker #(
    parameter int PORT_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    i_start,
    input logic [LEN_W-1:0]        i_len,
    input logic                    o_byte_ready,
    input logic                    o_rd_req,
    input logic [ADDR_W-1:0]       o_rd_addr,
    input logic                    i_rd_valid,
    input logic                    o_wr_valid,
    input logic [ADDR_W-1:0]       o_wr_addr,
    input logic [PORT_BYTES*8-1:0] o_wr_data,
    input logic                    i_wr_ready,
    input logic                    o_busy,
    input logic                    o_done
);
    localparam int LB = $clog2(PORT_BYTES);

    // R1: write addresses are port aligned.
    assert_wr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr_valid |-> (o_wr_addr[LB-1:0] == '0));

    // R7: read-back requests are for aligned words and wait for data.
    assert_rd_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        o_rd_req |-> (o_rd_addr[LB-1:0] == '0));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_rd_req && !i_rd_valid) |=> (o_rd_req && $stable(o_rd_addr)));

    // R2: stream bytes are not taken while a read-back or a write is pending.
    assert_stream_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_byte_ready |-> (!o_rd_req && !o_wr_valid));

    // R8: a zero-length start finishes in the next cycle.
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_busy && i_start && (i_len == '0)) |=> (o_done && !o_busy));

    // R12: a stalled write word keeps its address and data.
    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (o_wr_valid && !i_wr_ready) |=> (o_wr_valid && $stable(o_wr_addr) && $stable(o_wr_data)));

endmodule

bind flash_write_merger fwm_checker #(
    .PORT_BYTES(PORT_BYTES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
) u_fwm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_start     (i_start),
    .i_len       (i_len),
    .o_byte_ready(o_byte_ready),
    .o_rd_req    (o_rd_req),
    .o_rd_addr   (o_rd_addr),
    .i_rd_valid  (i_rd_valid),
    .o_wr_valid  (o_wr_valid),
    .o_wr_addr   (o_wr_addr),
    .o_wr_data   (o_wr_data),
    .i_wr_ready  (i_wr_ready),
    .o_busy      (o_busy),
    .o_done      (o_done)
);

// File: tb/test_flash_write_merger.sv
// Directed bench: big-endian and little-endian copies driven in lockstep.
module test_flash_write_merger;
    localparam int P     = 4;
    localparam int C     = 2;
    localparam int BUF   = 4;
    localparam int AW    = 32;
    localparam int LW    = 16;
    localparam int W     = P * 8;
    localparam int CHUNK = (P / C) * BUF / P;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          i_start = 1'b0;
    logic [AW-1:0] i_addr = '0;
    logic [LW-1:0] i_len = '0;
    logic          i_byte_valid = 1'b0;
    logic [7:0]    i_byte = '0;
    logic          i_rd_valid = 1'b0;
    logic [W-1:0]  rd_data_be = '0;
    logic [W-1:0]  rd_data_le = '0;
    logic          i_wr_ready = 1'b0;
    logic [7:0]    i_cmd_byte = '0;

    logic          byte_ready_b, rd_req_b, wr_valid_b, burst_end_b, busy_b, done_b;
    logic [AW-1:0] rd_addr_b, wr_addr_b;
    logic [W-1:0]  wr_data_b, cmd_b;
    logic          byte_ready_l, rd_req_l, wr_valid_l, burst_end_l, busy_l, done_l;
    logic [AW-1:0] rd_addr_l, wr_addr_l;
    logic [W-1:0]  wr_data_l, cmd_l;
    logic [W-1:0]  cmd_c1, cmd_c4;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    flash_write_merger #(.PORT_BYTES(P), .CHIP_BYTES(C), .BUF_SIZE(BUF),
                         .ADDR_W(AW), .LEN_W(LW), .BIG_ENDIAN(1'b1)) i_flash_write_merger (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_addr(i_addr), .i_len(i_len),
        .i_byte_valid(i_byte_valid), .i_byte(i_byte), .o_byte_ready(byte_ready_b),
        .o_rd_req(rd_req_b), .o_rd_addr(rd_addr_b), .i_rd_valid(i_rd_valid),
        .i_rd_data(rd_data_be), .o_wr_valid(wr_valid_b), .o_wr_addr(wr_addr_b),
        .o_wr_data(wr_data_b), .o_wr_burst_end(burst_end_b), .i_wr_ready(i_wr_ready),
        .o_busy(busy_b), .o_done(done_b), .i_cmd_byte(i_cmd_byte), .o_cmd_word(cmd_b));

    flash_write_merger #(.PORT_BYTES(P), .CHIP_BYTES(C), .BUF_SIZE(BUF),
                         .ADDR_W(AW), .LEN_W(LW), .BIG_ENDIAN(1'b0)) i_flash_write_merger_le (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_addr(i_addr), .i_len(i_len),
        .i_byte_valid(i_byte_valid), .i_byte(i_byte), .o_byte_ready(byte_ready_l),
        .o_rd_req(rd_req_l), .o_rd_addr(rd_addr_l), .i_rd_valid(i_rd_valid),
        .i_rd_data(rd_data_le), .o_wr_valid(wr_valid_l), .o_wr_addr(wr_addr_l),
        .o_wr_data(wr_data_l), .o_wr_burst_end(burst_end_l), .i_wr_ready(i_wr_ready),
        .o_busy(busy_l), .o_done(done_l), .i_cmd_byte(i_cmd_byte), .o_cmd_word(cmd_l));

    fwm_cmd_lanes #(.PORT_BYTES(P), .CHIP_BYTES(1), .BIG_ENDIAN(1'b1)) i_cmd_c1 (
        .i_cmd(i_cmd_byte), .o_word(cmd_c1));
    fwm_cmd_lanes #(.PORT_BYTES(P), .CHIP_BYTES(4), .BIG_ENDIAN(1'b0)) i_cmd_c4 (
        .i_cmd(i_cmd_byte), .o_word(cmd_c4));

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Flash contents model: byte at address a.
    function automatic logic [7:0] flash_b(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [W-1:0] flash_word(input logic [AW-1:0] w, input bit be);
        logic [W-1:0] r = '0;
        for (int k = 0; k < P; k++) begin
            if (be) r[(P-1-k)*8 +: 8] = flash_b(w + AW'(k));
            else    r[k*8 +: 8]       = flash_b(w + AW'(k));
        end
        return r;
    endfunction

    function automatic logic [W-1:0] cmd_expect(input logic [7:0] c, input int chip);
        logic [W-1:0] r = '0;
        for (int i = 0; i < P; i++)
            if (((i + 1) % chip) == 0) r[(P-1-i)*8 +: 8] = c;
        return r;
    endfunction

    // One request: build the expected word list, then serve stream, flash and sink.
    task automatic run_req(input string name, input logic [AW-1:0] a, input int n,
                           input logic [7:0] seed, input string rq);
        logic [AW-1:0] e_addr [16];
        logic [W-1:0]  e_be   [16];
        logic [W-1:0]  e_le   [16];
        bit            e_rd   [16];
        bit            e_end  [16];
        bit            rd_seen[16];
        logic [AW-1:0] wbase;
        logic [W-1:0]  held;
        int nw, idx, got, cyc, runpos;
        bit fin, hold_pend;

        wbase = a & ~AW'(P - 1);
        nw = (n == 0) ? 0 : (int'(((a + AW'(n) - 1) & ~AW'(P - 1)) - wbase) / P + 1);
        for (int wi = 0; wi < nw; wi++) begin
            e_addr[wi] = wbase + AW'(P * wi);
            e_rd[wi] = 1'b0;
            rd_seen[wi] = 1'b0;
            e_be[wi] = '0;
            e_le[wi] = '0;
            for (int k = 0; k < P; k++) begin
                logic [AW-1:0] ba;
                logic [7:0] b;
                ba = e_addr[wi] + AW'(k);
                if (ba >= a && ba < a + AW'(n)) b = seed + 8'(ba - a);
                else begin b = flash_b(ba); e_rd[wi] = 1'b1; end
                e_be[wi][(P-1-k)*8 +: 8] = b;
                e_le[wi][k*8 +: 8] = b;
            end
        end
        runpos = -1;
        for (int wi = 0; wi < nw; wi++) begin
            if (e_rd[wi]) begin
                e_end[wi] = 1'b1;
                runpos = -1;
            end else begin
                bit nxt_body;
                runpos++;
                nxt_body = (wi + 1 < nw) && !e_rd[wi+1];
                e_end[wi] = ((runpos % CHUNK) == CHUNK - 1) || !nxt_body;
                if (!nxt_body) runpos = -1;
            end
        end

        @(negedge clk);
        i_start = 1'b1;
        i_addr = a;
        i_len = LW'(n);
        idx = 0; got = 0; cyc = 0; fin = 0; hold_pend = 0; held = '0;
        while (!fin && cyc < 2000) begin
            @(negedge clk);
            i_start = 1'b0;
            i_byte_valid = (idx < n);
            i_byte = seed + 8'(idx);
            i_rd_valid = rd_req_b;
            rd_data_be = flash_word(rd_addr_b, 1'b1);
            rd_data_le = flash_word(rd_addr_l, 1'b0);
            i_wr_ready = ((cyc % 3) != 1);
            #1;
            if (hold_pend) begin
                check(wr_valid_b && (wr_data_b == held), "R12", {name, " stalled word held"},
                      wr_data_b, held);
                hold_pend = 0;
            end
            if (byte_ready_b && i_byte_valid) idx++;
            if (rd_req_b) begin
                check(got < nw && e_rd[got] && rd_addr_b == e_addr[got], "R7",
                      {name, " read-back only for partial word"}, W'(rd_addr_b),
                      W'(got < nw ? e_addr[got] : '1));
                if (got < nw) rd_seen[got] = 1'b1;
            end
            if (wr_valid_b) begin
                if (i_wr_ready) begin
                    if (got < nw) begin
                        check(wr_addr_b == e_addr[got], "R1", {name, " word address"},
                              W'(wr_addr_b), W'(e_addr[got]));
                        check(wr_data_b == e_be[got], {"R5 ", rq}, {name, " big-endian word"},
                              wr_data_b, e_be[got]);
                        check(wr_data_l == e_le[got], {"R6 ", rq}, {name, " little-endian word"},
                              wr_data_l, e_le[got]);
                        check(burst_end_b == e_end[got] && burst_end_l == e_end[got], "R10",
                              {name, " burst end"}, W'(burst_end_b), W'(e_end[got]));
                        check(rd_seen[got] == e_rd[got], "R7", {name, " read-back presence"},
                              W'(rd_seen[got]), W'(e_rd[got]));
                    end else begin
                        check(1'b0, rq, {name, " extra word"}, W'(wr_addr_b), '0);
                    end
                    got++;
                end else begin
                    held = wr_data_b;
                    hold_pend = 1;
                end
            end
            if (done_b) fin = 1;
            cyc++;
        end
        i_byte_valid = 1'b0;
        i_rd_valid = 1'b0;
        check(fin && got == nw, rq, {name, " word count and completion"}, W'(got), W'(nw));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!wr_valid_b && !rd_req_b && !byte_ready_b && !busy_b && !done_b, "R11",
              "outputs after reset", W'({wr_valid_b, rd_req_b, byte_ready_b, busy_b, done_b}), '0);
    endtask

    task automatic t_aligned_pair();
        run_req("aligned 8 bytes", 32'h0000_0100, 8, 8'h10, "R5");
    endtask

    task automatic t_head_inside();
        run_req("head offset 1 len 2", 32'h0000_0201, 2, 8'h20, "R3");
    endtask

    task automatic t_head_body_tail();
        run_req("offset 3 len 11", 32'h0000_0303, 11, 8'h30, "R2 R4");
    endtask

    task automatic t_long_body();
        run_req("aligned 20 bytes", 32'h0000_0400, 20, 8'h40, "R10");
    endtask

    task automatic t_single_tail();
        run_req("aligned len 1", 32'h0000_0500, 1, 8'h50, "R4");
    endtask

    task automatic t_zero_len();
        run_req("zero length", 32'h0000_0602, 0, 8'h60, "R8");
        repeat (3) begin
            @(negedge clk);
            check(!wr_valid_b && !rd_req_b && !busy_b, "R8", "idle after zero length",
                  W'({wr_valid_b, rd_req_b, busy_b}), '0);
        end
    endtask

    task automatic t_cmd();
        i_cmd_byte = 8'h98;
        #1;
        check(cmd_b == cmd_expect(8'h98, C), "R9", "command big-endian x2", cmd_b, cmd_expect(8'h98, C));
        check(cmd_l == cmd_expect(8'h98, C), "R9", "command little-endian x2", cmd_l, cmd_expect(8'h98, C));
        check(cmd_c1 == cmd_expect(8'h98, 1), "R9", "command byte-wide chips", cmd_c1, cmd_expect(8'h98, 1));
        check(cmd_c4 == cmd_expect(8'h98, 4), "R9", "command one chip", cmd_c4, cmd_expect(8'h98, 4));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_aligned_pair();
        t_head_inside();
        t_head_body_tail();
        t_long_body();
        t_single_tail();
        t_zero_len();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule